// File: doc/BRIEF.md
# Boundary Test Access Port with Device-Reset Chain

This block is a four-wire boundary test access port controller. It is clocked by the test clock and runs the standard sixteen-state controller, steered by the mode-select input. A four-bit instruction register chooses which data register sits between the serial input and the serial output: a single bypass cell, a boundary chain of configurable length, or a single device-reset cell.

The boundary chain loads the parallel pin samples during data capture. It shifts them out least significant bit first. On data update it copies its contents into a bank of hold latches. Those latches are brought out as plain outputs and never reach any pad. The reset cell drives the system reset request directly, with no update stage. The system can therefore be held in reset for as long as the cell holds a one, and the controller keeps accepting scans during that time.

Top module: `jtag_tap_rst`

## Requirements
- R1: When `trst` is high at a rising `tck` edge, or after five consecutive rising edges with `tms` high, the controller sits in its reset state. In that state the instruction register holds bypass (4'hF), the reset cell is cleared so `sys_rst_req` is 0, and `tdo_en` is 0. `trst` also clears `upd_q` to zero.
- R2: During instruction capture the instruction shift register loads 4'b0001. It shifts least significant bit first, with `tdi` entering at bit 3. The decoded instruction changes only on the falling `tck` edge while in the instruction-update state, or when the controller is in its reset state.
- R3: With opcode 4'h2 selected, data capture loads `pin_in` into the boundary chain. Each data shift moves `tdi` into the top bit, and `tdo` presents bit 0 first.
- R4: With opcode 4'h2 selected, the falling `tck` edge in the data-update state copies the boundary chain into `upd_q`. Under any other instruction, and in any other state, `upd_q` holds its value.
- R5: With opcode 4'hF or any opcode other than 4'h2 and 4'hC selected, data capture loads 0 into the bypass cell. Data shift then delays `tdi` to `tdo` by exactly one cell.
- R6: With opcode 4'hC selected, data shift moves `tdi` through a single reset cell. `sys_rst_req` equals that cell at all times. The cell is unchanged by capture, by update and by other instructions, and is cleared only by the reset state of R1.
- R7: While `sys_rst_req` is high, the controller continues to move through its states and to load and decode new instructions.
- R8: `tdo` and `tdo_en` change only on the falling `tck` edge. `tdo_en` is 1 exactly when the controller is in the instruction-shift or data-shift state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| pin_in | input | BSR_LEN | Parallel pin samples captured by the boundary chain |
| tdo | output | 1 | Serial data out, changes on falling tck |
| tdo_en | output | 1 | Output enable for tdo; 0 stands for high impedance |
| sys_rst_req | output | 1 | System reset request taken straight from the reset cell |
| upd_q | output | BSR_LEN | Boundary update latches, not connected to pads |

## Verification
The bench looks at the moment the reset cell changes its value. It shows that a design that latched the cell at update would raise `sys_rst_req` too late, and that one that cleared it on capture would drop the reset in the middle of a scan. A reset cell that starts at one is shifted out, which makes a bypass-style capture of zero visible on the first `tdo` bit. An unused opcode is loaded to catch a decoder that routes it to the boundary chain rather than bypass. The bench also reads back the capture pattern while the reset request is high, and applies a five-cycle `tms` reset with the request raised, so that a controller that stalls under reset, or that keeps the cell set through its reset state, produces a mismatch.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;
  localparam int unsigned IR_LEN = 4;

  localparam logic [IR_LEN-1:0] OP_SAMPLE  = 4'h2;
  localparam logic [IR_LEN-1:0] OP_DEVRST  = 4'hC;
  localparam logic [IR_LEN-1:0] OP_BYPASS  = 4'hF;
  localparam logic [IR_LEN-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [3:0] {
    S_TLR, S_RTI,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_t;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst,
  input  logic       tms,
  output tap_state_t st
);
  tap_state_t nxt;

  always_comb begin
    unique case (st)
      S_TLR:    nxt = tms ? S_TLR    : S_RTI;
      S_RTI:    nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nxt = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  nxt = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: nxt = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: nxt = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: nxt = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: nxt = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: nxt = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  nxt = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: nxt = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: nxt = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: nxt = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: nxt = tms ? S_SEL_DR : S_RTI;
      default:  nxt = S_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (trst) st <= S_TLR;
    else      st <= nxt;
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_tap_pkg::*;
(
  input  logic              tck,
  input  logic              trst,
  input  tap_state_t        st,
  input  logic              tdi,
  output logic              ir_lsb,
  output logic [IR_LEN-1:0] ir_q
);
  logic [IR_LEN-1:0] ir_sr;

  always_ff @(posedge tck) begin
    if (trst)                ir_sr <= IR_CAPTURE;
    else if (st == S_CAP_IR) ir_sr <= IR_CAPTURE;
    else if (st == S_SH_IR)  ir_sr <= {tdi, ir_sr[IR_LEN-1:1]};
  end

  // Decoded instruction is committed on the falling edge
  always_ff @(negedge tck) begin
    if (trst || st == S_TLR) ir_q <= OP_BYPASS;
    else if (st == S_UPD_IR) ir_q <= ir_sr;
  end

  assign ir_lsb = ir_sr[0];
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int unsigned BSR_LEN = 8
) (
  input  logic               tck,
  input  logic               trst,
  input  tap_state_t         st,
  input  logic               tdi,
  input  logic               sel_bsr,
  input  logic               sel_rst,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic               bsr_lsb,
  output logic               byp,
  output logic               rst_cell,
  output logic [BSR_LEN-1:0] upd_q
);
  logic [BSR_LEN-1:0] bsr_sr;
  logic               sel_byp;

  assign sel_byp = !sel_bsr && !sel_rst;

  // Boundary chain: parallel capture, LSB-first serial shift
  always_ff @(posedge tck) begin
    if (trst)                           bsr_sr <= '0;
    else if (sel_bsr && st == S_CAP_DR) bsr_sr <= pin_in;
    else if (sel_bsr && st == S_SH_DR)  bsr_sr <= {tdi, bsr_sr[BSR_LEN-1:1]};
  end

  // Update latches, written on the falling edge
  always_ff @(negedge tck) begin
    if (trst)                           upd_q <= '0;
    else if (sel_bsr && st == S_UPD_DR) upd_q <= bsr_sr;
  end

  always_ff @(posedge tck) begin
    if (trst)                           byp <= 1'b0;
    else if (sel_byp && st == S_CAP_DR) byp <= 1'b0;
    else if (sel_byp && st == S_SH_DR)  byp <= tdi;
  end

  // Reset cell: no capture, no update stage; cleared only in reset state
  always_ff @(posedge tck) begin
    if (trst || st == S_TLR)            rst_cell <= 1'b0;
    else if (sel_rst && st == S_SH_DR)  rst_cell <= tdi;
  end

  assign bsr_lsb = bsr_sr[0];
endmodule

// File: rtl/jtag_tap_rst.sv
module jtag_tap_rst
  import jtag_tap_pkg::*;
#(
  parameter int unsigned BSR_LEN = 8
) (
  input  logic               tck,
  input  logic               trst,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic               tdo,
  output logic               tdo_en,
  output logic               sys_rst_req,
  output logic [BSR_LEN-1:0] upd_q
);
  tap_state_t        st;
  logic [IR_LEN-1:0] ir_q;
  logic              ir_lsb, bsr_lsb, dr_byp, rst_cell;
  logic              sel_bsr, sel_rst, tdo_nxt;

  tap_fsm u_fsm (.tck(tck), .trst(trst), .tms(tms), .st(st));

  tap_ir u_ir (
    .tck(tck), .trst(trst), .st(st), .tdi(tdi),
    .ir_lsb(ir_lsb), .ir_q(ir_q)
  );

  assign sel_bsr = (ir_q == OP_SAMPLE);
  assign sel_rst = (ir_q == OP_DEVRST);

  tap_dr #(.BSR_LEN(BSR_LEN)) u_dr (
    .tck(tck), .trst(trst), .st(st), .tdi(tdi),
    .sel_bsr(sel_bsr), .sel_rst(sel_rst), .pin_in(pin_in),
    .bsr_lsb(bsr_lsb), .byp(dr_byp), .rst_cell(rst_cell), .upd_q(upd_q)
  );

  always_comb begin
    if (st == S_SH_IR) tdo_nxt = ir_lsb;
    else if (sel_bsr)  tdo_nxt = bsr_lsb;
    else if (sel_rst)  tdo_nxt = rst_cell;
    else               tdo_nxt = dr_byp;
  end

  always_ff @(negedge tck) begin
    if (trst) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= tdo_nxt;
      tdo_en <= (st == S_SH_IR) || (st == S_SH_DR);
    end
  end

  assign sys_rst_req = rst_cell;
endmodule

// File: rtl/jtag_tap_rst_chk.sv
module jtag_tap_rst_chk
  import jtag_tap_pkg::*;
#(
  parameter int unsigned BSR_LEN = 8
) (
  input logic               tck,
  input logic               trst,
  input tap_state_t         st,
  input logic [IR_LEN-1:0]  ir_q,
  input logic [BSR_LEN-1:0] upd_q,
  input logic               sys_rst_req,
  input logic               tdo_en,
  input logic               dr_byp,
  input logic               sel_bsr,
  input logic               sel_rst
);
  a_r1_trst_clears_rst: assert property (@(posedge tck)
    trst |=> !sys_rst_req);

  a_r2_ir_change_point: assert property (@(posedge tck) disable iff (trst)
    !$stable(ir_q) |-> (st == S_UPD_IR || st == S_TLR));

  a_r4_upd_hold: assert property (@(posedge tck) disable iff (trst)
    !$stable(upd_q) |-> (st == S_UPD_DR && sel_bsr));

  a_r5_bypass_capture_zero: assert property (@(posedge tck) disable iff (trst)
    (st == S_CAP_DR && !sel_bsr && !sel_rst) |=> !dr_byp);

  a_r6_rst_cell_hold: assert property (@(posedge tck) disable iff (trst)
    (st != S_SH_DR && st != S_TLR) |=> $stable(sys_rst_req));

  a_r8_tdo_en_window: assert property (@(posedge tck) disable iff (trst)
    tdo_en == (st == S_SH_IR || st == S_SH_DR));
endmodule

bind jtag_tap_rst jtag_tap_rst_chk #(.BSR_LEN(BSR_LEN)) chk_i (
  .tck(tck), .trst(trst), .st(st), .ir_q(ir_q), .upd_q(upd_q),
  .sys_rst_req(sys_rst_req), .tdo_en(tdo_en), .dr_byp(dr_byp),
  .sel_bsr(sel_bsr), .sel_rst(sel_rst)
);

// File: tb/jtag_tap_rst_tb_top.sv
`timescale 1ns/1ps
module jtag_tap_rst_tb_top;
  localparam int N = 8;

  logic tck = 1'b0;
  logic trst = 1'b1;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic [N-1:0] pin_in = '0;
  logic tdo, tdo_en, sys_rst_req;
  logic [N-1:0] upd_q;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 tck = ~tck;

  jtag_tap_rst #(.BSR_LEN(N)) dut_i (
    .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .pin_in(pin_in),
    .tdo(tdo), .tdo_en(tdo_en), .sys_rst_req(sys_rst_req), .upd_q(upd_q)
  );

  // {opcode, pins, shift-in, expected tdo word, expected upd_q, expected reset}
  localparam int NV = 7;
  localparam logic [36:0] VEC [NV] = '{
    {4'h2, 8'hA5, 8'h3C, 8'hA5, 8'h3C, 1'b0},
    {4'hF, 8'h00, 8'h81, 8'h02, 8'h3C, 1'b0},
    {4'h5, 8'h00, 8'hFF, 8'hFE, 8'h3C, 1'b0},
    {4'hC, 8'h00, 8'h80, 8'h00, 8'h3C, 1'b1},
    {4'h2, 8'h5A, 8'hC3, 8'h5A, 8'hC3, 1'b1},
    {4'hC, 8'h00, 8'h01, 8'h03, 8'hC3, 1'b0},
    {4'h2, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic load_ir(input logic [3:0] op, output logic [3:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin
      cap[i] = tdo;
      step(i == 3, op[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input logic [N-1:0] din, output logic [N-1:0] dout, output logic en0);
    step(1, 0); step(0, 0); step(0, 0);
    en0 = tdo_en;
    for (int i = 0; i < N; i++) begin
      dout[i] = tdo;
      step(i == N - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0] cap;
    logic [N-1:0] dout;
    logic en0;

    repeat (4) @(negedge tck);
    #1;
    trst = 1'b0;
    // R1: reset state
    chk(tdo_en == 0, "R1 tdo_en after trst", tdo_en, 0);
    chk(sys_rst_req == 0, "R1 sys_rst_req after trst", sys_rst_req, 0);
    chk(upd_q == 0, "R1 upd_q after trst", upd_q, 0);
    step(0, 0);
    chk(tdo_en == 0, "R8 tdo_en idle", tdo_en, 0);

    // R1: default instruction after reset is bypass
    scan_dr(8'h81, dout, en0);
    chk(dout == 8'h02, "R1 bypass after reset", dout, 8'h02);
    chk(en0 == 1, "R8 tdo_en in shift-dr", en0, 1);

    for (int v = 0; v < NV; v++) begin
      logic [3:0] op;
      logic [N-1:0] pins, din, etdo, eupd;
      logic erst;
      {op, pins, din, etdo, eupd, erst} = VEC[v];
      load_ir(op, cap);
      chk(cap == 4'b0001, "R2 ir capture pattern", cap, 1);
      pin_in = pins;
      scan_dr(din, dout, en0);
      // R3 (sample), R5 (bypass/unused), R6 (reset cell)
      chk(dout == etdo, (op == 4'h2) ? "R3 boundary tdo" : (op == 4'hC) ? "R6 reset cell tdo" : "R5 bypass tdo", dout, etdo);
      chk(upd_q == eupd, "R4 update latches", upd_q, eupd);
      chk(sys_rst_req == erst, "R6 sys_rst_req", sys_rst_req, erst);
    end

    // R6: reset cell goes high during shift, before update
    load_ir(4'hC, cap);
    step(1, 0); step(0, 0); step(0, 0);
    step(0, 1'b1);
    chk(sys_rst_req == 1, "R6 reset asserted mid-shift", sys_rst_req, 1);
    step(1, 1'b1); step(1, 0); step(0, 0);
    chk(sys_rst_req == 1, "R6 reset held after update", sys_rst_req, 1);

    // R7: TAP still runs with reset request high
    load_ir(4'h2, cap);
    chk(cap == 4'b0001, "R7 ir capture while reset high", cap, 1);
    pin_in = 8'h96;
    scan_dr(8'h00, dout, en0);
    chk(dout == 8'h96, "R7 boundary scan while reset high", dout, 8'h96);
    chk(sys_rst_req == 1, "R6 reset kept under other opcode", sys_rst_req, 1);

    // R1: five tms-high cycles return to reset state
    repeat (5) step(1, 0);
    chk(sys_rst_req == 0, "R1 tms reset clears reset cell", sys_rst_req, 0);
    step(0, 0);
    scan_dr(8'h40, dout, en0);
    chk(dout == 8'h80, "R1 bypass after tms reset", dout, 8'h80);
    chk(upd_q == 8'h00, "R4 upd_q held under bypass", upd_q, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule